// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a two-wire serial slave that holds a small bank of 8-bit configuration registers, such as output enable bits, and presents their contents as one parallel bus. A host reaches it through the usual two-line serial bus: SCL and SDA come in as plain inputs. The slave pulls SDA low through a single open-drain enable output. Every register loads a parameter default at reset, so a system that never touches the bus still sees a usable configuration.

Four operations are supported. The host picks one with bit 7 of the command byte that follows the address. A 1 selects single-register access, and bits 6:0 then give the register offset. A 0 selects a block transfer, which always starts at register zero and carries a length byte. The host may end a block transfer after any whole byte. Both SCL and SDA are brought into the system clock domain and edge-detected there. The protocol runs in one state machine. Its states are IDLE, ADDR (shift in the address byte), ADDR_ACK, CMD (shift in the command), CMD_ACK, WDATA (shift in a length or data byte), WDATA_ACK, TX (shift out a byte), TX_ACK (sample the host's acknowledge) and SKIP (released, waiting for the next start or stop).

The transitions are these. A start condition leads from any state to ADDR, and a stop condition leads to IDLE. In ADDR, at the SCL fall that ends the eighth bit, the machine goes to ADDR_ACK if the address matches, and to SKIP if it does not. When ADDR_ACK ends, it goes to TX if the read bit is set and to CMD otherwise. CMD goes to CMD_ACK, and CMD_ACK goes to WDATA. WDATA and WDATA_ACK alternate. TX goes to TX_ACK, and TX_ACK returns to TX on a host acknowledge or goes to SKIP on a not-acknowledge.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset, register i holds byte i of the default parameter (register i sits at bits 8i+7:8i of `regs_o`), and `sda_oe` is 0.
- R2: The slave acknowledges address byte D2h (7-bit address 69h, write) and D3h (read). It ignores any other address: it acknowledges none of the following bytes and changes no register until the next start condition.
- R3: A byte write (start, D2h, command with bit 7 = 1 and bits 6:0 = offset, data, stop) stores the data in register `offset`, and the slave acknowledges every byte.
- R4: A byte read (start, D2h, command with bit 7 = 1 and offset, repeated start, D3h) returns register `offset` most significant bit first.
- R5: A block write (command 00h) takes the first data byte as a length and stores nothing from it. The bytes after it go to registers 0, 1, 2 and so on in order. A stop after any whole byte leaves the remaining registers unchanged.
- R6: A block read (command 00h, repeated start, D3h) first returns the number of registers (4 by default) and then registers 0, 1, 2 and so on in ascending order.
- R7: A host not-acknowledge on a read byte ends the transfer. The slave releases SDA and drives nothing on any further SCL pulse before the next start.
- R8: A write to an offset at or above the register count is acknowledged and discarded. A read of such an offset returns 00h.
- R9: A start is detected as SDA falling while SCL is high, and a stop as SDA rising while SCL is high. A start in the middle of a byte restarts address reception.
- R10: The slave changes `sda_oe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| regs_o | output | NUM_REGS*8 | Register contents, register i at bits 8i+7:8i |

## Verification
The bench goes after the length byte of a block write. A slave that stored that byte would shift every register by one. It also reads an offset past the last register: a decoder that wraps or leaves bits undecoded would alias a real register, or would refuse the acknowledge and stall the host. Two further cases are a host not-acknowledge followed by an extra SCL pulse, and a repeated start after three bits of a data byte. A slave that failed on the first would go on driving data onto the bus. A slave that failed on the second would lose byte alignment and write garbage. An address one below the slave's own checks that a slave with a faulty address compare neither answers nor writes.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_CMD,
        S_CMD_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_TX,
        S_TX_ACK,
        S_SKIP
    } smb_state_e;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_ff;
    logic [SYNC_STAGES-1:0] sda_ff;
    logic                   scl_q;
    logic                   sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
            scl_q  <= scl_o;
            sda_q  <= sda_o;
        end
    end

    assign scl_o     = scl_ff[SYNC_STAGES-1];
    assign sda_o     = sda_ff[SYNC_STAGES-1];
    assign scl_rise  = scl_o & ~scl_q;
    assign scl_fall  = ~scl_o & scl_q;
    assign start_det = scl_o & scl_q & sda_q & ~sda_o;
    assign stop_det  = scl_o & scl_q & ~sda_q & sda_o;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
    parameter int                      NUM_REGS = 4,
    parameter int                      AW       = 7,
    parameter logic [NUM_REGS*8-1:0]   DEFAULTS = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [AW-1:0]         waddr,
    input  logic [7:0]            wdata,
    input  logic [AW-1:0]         raddr,
    output logic [7:0]            rdata,
    output logic [NUM_REGS*8-1:0] regs_o
);

    localparam logic [AW:0] LIMIT = (AW+1)'(NUM_REGS);

    logic [7:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= DEFAULTS[8*g +: 8];
            end else if (we && waddr == AW'(g)) begin
                regs[g] <= wdata;
            end
        end
        assign regs_o[8*g +: 8] = regs[g];
    end

    // Offsets with no register behind them read as zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (raddr == AW'(i)) rdata = regs[i];
        end
    end

    // R8: a write past the last register leaves the bank untouched
    p_oob_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && {1'b0, waddr} >= LIMIT) |=> $stable(regs_o))
        else $error("R8: out-of-range write changed a register");

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
    parameter int                    NUM_REGS     = 4,
    parameter logic [6:0]            DEV_ADDR     = 7'h69,
    parameter logic [NUM_REGS*8-1:0] REG_DEFAULTS = (NUM_REGS*8)'(32'h4433_2211)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] regs_o
);
    import smb_cfg_pkg::*;

    localparam int         AW         = 7;
    localparam logic [7:0] COUNT_BYTE = 8'(NUM_REGS);

    smb_state_e    state, state_n;
    logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0]    sh;
    logic [3:0]    bit_cnt;
    logic          rw_q;
    logic          cnt_pend;
    logic          m_ack;
    logic [AW-1:0] ptr;
    logic [7:0]    tx_sh;
    logic [7:0]    rdata;
    logic          we;
    logic          byte_end;
    logic          tx_load;

    smb_line_sync #(.SYNC_STAGES(2)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_o     (scl_s),
        .sda_o     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .AW       (AW),
        .DEFAULTS (REG_DEFAULTS)
    ) i_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (we),
        .waddr  (ptr),
        .wdata  (sh),
        .raddr  (ptr),
        .rdata  (rdata),
        .regs_o (regs_o)
    );

    assign byte_end = scl_fall && (bit_cnt == 4'd8);
    assign we       = (state == S_WDATA) && byte_end && !cnt_pend;
    assign tx_load  = (state_n == S_TX) && (state != S_TX);

    // Next-state logic
    always_comb begin
        state_n = state;
        if (start_det) begin
            state_n = S_ADDR;
        end else if (stop_det) begin
            state_n = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:      state_n = S_IDLE;
                S_ADDR:      if (byte_end) state_n = (sh[7:1] == DEV_ADDR) ? S_ADDR_ACK : S_SKIP;
                S_ADDR_ACK:  if (scl_fall) state_n = rw_q ? S_TX : S_CMD;
                S_CMD:       if (byte_end) state_n = S_CMD_ACK;
                S_CMD_ACK:   if (scl_fall) state_n = S_WDATA;
                S_WDATA:     if (byte_end) state_n = S_WDATA_ACK;
                S_WDATA_ACK: if (scl_fall) state_n = S_WDATA;
                S_TX:        if (byte_end) state_n = S_TX_ACK;
                S_TX_ACK:    if (scl_fall) state_n = m_ack ? S_TX : S_SKIP;
                S_SKIP:      state_n = S_SKIP;
                default:     state_n = S_IDLE;
            endcase
        end
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            sh       <= '0;
            bit_cnt  <= '0;
            rw_q     <= 1'b0;
            cnt_pend <= 1'b0;
            m_ack    <= 1'b0;
            ptr      <= '0;
            tx_sh    <= '0;
        end else begin
            state <= state_n;

            if (start_det || state_n != state) begin
                bit_cnt <= '0;
            end else if (scl_rise && bit_cnt != 4'd8) begin
                bit_cnt <= bit_cnt + 4'd1;
            end

            if (scl_rise) sh <= {sh[6:0], sda_s};

            if (state == S_ADDR && byte_end) rw_q <= sh[0];

            if (state == S_CMD && byte_end) begin
                cnt_pend <= ~sh[7];
                ptr      <= sh[7] ? sh[6:0] : '0;
            end else if (state == S_WDATA && byte_end) begin
                if (cnt_pend) cnt_pend <= 1'b0;
                else          ptr      <= ptr + 7'd1;
            end else if (tx_load && !start_det && !stop_det) begin
                if (cnt_pend) begin
                    tx_sh    <= COUNT_BYTE;
                    cnt_pend <= 1'b0;
                end else begin
                    tx_sh <= rdata;
                    ptr   <= ptr + 7'd1;
                end
            end else if (state == S_TX && scl_fall && bit_cnt != 4'd8) begin
                tx_sh <= {tx_sh[6:0], 1'b0};
            end

            if (state == S_TX_ACK && scl_rise) m_ack <= ~sda_s;
        end
    end

    // Output logic
    always_comb begin
        unique case (state)
            S_ADDR_ACK, S_CMD_ACK, S_WDATA_ACK: sda_oe = 1'b1;
            S_TX:                               sda_oe = ~tx_sh[7];
            default:                            sda_oe = 1'b0;
        endcase
    end

    // R9: a start always reopens address reception
    p_start_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == S_ADDR))
        else $error("R9: start did not restart address phase");

    // R9: a stop returns the slave to idle with SDA released
    p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == S_IDLE && !sda_oe))
        else $error("R9: stop did not release the slave");

    // R10: the SDA drive moves only while SCL is low
    p_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s)
        else $error("R10: SDA drive changed with SCL high");

    // R2: a foreign address gets no acknowledge
    p_no_ack_foreign_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADDR && byte_end && !start_det && !stop_det && sh[7:1] != DEV_ADDR)
            |=> (!sda_oe && state == S_SKIP))
        else $error("R2: foreign address acknowledged");

    // R7: once the host refuses a byte, the slave stays off the bus
    p_release_after_nack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SKIP) |-> !sda_oe)
        else $error("R7: SDA driven after host not-acknowledge");

endmodule

// File: tb/test_smb_cfg_slave.sv
module test_smb_cfg_slave;

    localparam int          CLK_PERIOD = 10;
    localparam int          Q          = 8;
    localparam int          NREG       = 4;
    localparam logic [6:0]  DEV        = 7'h69;
    localparam logic [31:0] DEFS       = 32'h4433_2211;
    localparam logic [7:0]  AW_W       = {DEV, 1'b0};
    localparam logic [7:0]  AW_R       = {DEV, 1'b1};

    // Each entry: {offset[6:0], write data[7:0], expected read-back[7:0]}
    localparam int          NVEC = 6;
    localparam logic [22:0] VEC [NVEC] = '{
        {7'd0,   8'hDE, 8'hDE},
        {7'd3,   8'h5A, 8'h5A},
        {7'd1,   8'h00, 8'h00},
        {7'd2,   8'hFF, 8'hFF},
        {7'd4,   8'h77, 8'h00},
        {7'd127, 8'hC3, 8'h00}
    };

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_low = 1'b0;
    logic        sda_oe;
    logic        sda_bus;
    logic [31:0] regs;
    logic [7:0]  model [NREG];
    int          n_tests = 0;
    int          n_fail  = 0;
    int          oe_viol = 0;

    assign sda_bus = ~(m_low | sda_oe);

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_cfg_slave #(.NUM_REGS(NREG), .DEV_ADDR(DEV), .REG_DEFAULTS(DEFS)) i_smb_cfg_slave (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (m_scl),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe),
        .regs_o (regs)
    );

    // R10 monitor: count any change of the slave's drive while SCL is high
    always @(sda_oe) if (rst_n && m_scl) oe_viol++;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hq;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start;
        m_low = 1'b0; hq;
        m_scl = 1'b1; hq;
        m_low = 1'b1; hq;
        m_scl = 1'b0; hq;
    endtask

    task automatic bus_stop;
        m_low = 1'b1; hq;
        m_scl = 1'b1; hq;
        m_low = 1'b0; hq;
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            m_low = ~b[7-i]; hq;
            m_scl = 1'b1;    hq;
            m_scl = 1'b0;    hq;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        m_low = 1'b0; hq;
        m_scl = 1'b1; hq;
        ack   = ~sda_bus;
        m_scl = 1'b0; hq;
    endtask

    task automatic recv_byte(input bit nack, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            hq;
            m_scl = 1'b1; hq;
            b[i]  = sda_bus;
            m_scl = 1'b0;
        end
        m_low = ~nack; hq;
        m_scl = 1'b1;  hq;
        m_scl = 1'b0;  hq;
        m_low = 1'b0;
    endtask

    task automatic chk_regs(input string tag);
        for (int i = 0; i < NREG; i++)
            chk(regs[8*i +: 8] == model[i], tag, regs[8*i +: 8], model[i]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit         a0, a1, a2, a3, a4;
        logic [7:0] rb;
        for (int i = 0; i < NREG; i++) model[i] = DEFS[8*i +: 8];

        repeat (5) @(negedge clk);
        chk(regs == DEFS, "R1 reset register values", regs, DEFS);
        chk(sda_oe == 1'b0, "R1 reset sda_oe", 32'(sda_oe), 0);
        rst_n = 1'b1;
        hq;
        chk(sda_bus == 1'b1, "R1 bus idle after reset", 32'(sda_bus), 1);

        // Table walk: R3/R8 byte write, then R4/R8 byte read-back
        for (int v = 0; v < NVEC; v++) begin
            logic [6:0] off;
            logic [7:0] wd, ex;
            {off, wd, ex} = VEC[v];
            bus_start;
            send_byte(AW_W, a0);
            send_byte({1'b1, off}, a1);
            send_byte(wd, a2);
            bus_stop;
            chk(a0 && a1 && a2, "R3/R8 byte write acknowledged", {a0, a1, a2}, 3'b111);
            if (int'(off) < NREG) model[off] = wd;
            chk_regs("R3/R8 registers after byte write");

            bus_start;
            send_byte(AW_W, a0);
            send_byte({1'b1, off}, a1);
            bus_start;
            send_byte(AW_R, a2);
            recv_byte(1'b1, rb);
            bus_stop;
            chk(a0 && a1 && a2, "R4 byte read acknowledged", {a0, a1, a2}, 3'b111);
            chk(rb == ex, "R4/R8 byte read value", rb, ex);
        end

        // R2: foreign address, the following bytes must be ignored
        bus_start;
        send_byte({7'h68, 1'b0}, a0);
        send_byte(8'h80, a1);
        send_byte(8'h99, a2);
        bus_stop;
        chk(!a0, "R2 foreign address not acknowledged", 32'(a0), 0);
        chk(!a1 && !a2, "R2 bytes after foreign address ignored", {a1, a2}, 0);
        chk_regs("R2 registers unchanged by foreign address");

        // R5: block write of two bytes, length byte discarded, stop early
        bus_start;
        send_byte(AW_W, a0);
        send_byte(8'h00, a1);
        send_byte(8'h02, a2);
        send_byte(8'h10, a3);
        send_byte(8'h20, a4);
        bus_stop;
        chk(a0 && a1 && a2 && a3 && a4, "R5 block write acknowledged", {a0, a1, a2, a3, a4}, 5'h1F);
        model[0] = 8'h10;
        model[1] = 8'h20;
        chk_regs("R5 registers after block write");

        // R6: block read, count first then registers in ascending order
        bus_start;
        send_byte(AW_W, a0);
        send_byte(8'h00, a1);
        bus_start;
        send_byte(AW_R, a2);
        recv_byte(1'b0, rb);
        chk(rb == 8'(NREG), "R6 block read count byte", rb, NREG);
        for (int i = 0; i < NREG; i++) begin
            recv_byte(i == NREG - 1, rb);
            chk(rb == model[i], "R6 block read data", rb, model[i]);
        end
        bus_stop;
        chk(a0 && a1 && a2, "R6 block read acknowledged", {a0, a1, a2}, 3'b111);

        // R7: host not-acknowledge, slave must stay released
        bus_start;
        send_byte(AW_W, a0);
        send_byte(8'h83, a1);
        bus_start;
        send_byte(AW_R, a2);
        recv_byte(1'b1, rb);
        chk(sda_oe == 1'b0, "R7 SDA released after not-acknowledge", 32'(sda_oe), 0);
        m_scl = 1'b1; hq;
        chk(sda_bus == 1'b1, "R7 no drive on extra SCL pulse", 32'(sda_bus), 1);
        m_scl = 1'b0; hq;
        bus_stop;
        chk(rb == model[3], "R7 value before not-acknowledge", rb, model[3]);

        // R9: repeated start three bits into a data byte
        bus_start;
        send_byte(AW_W, a0);
        send_byte(8'h81, a1);
        send_bits(8'hFF, 3);
        bus_start;
        send_byte(AW_W, a2);
        send_byte(8'h81, a3);
        send_byte(8'h3E, a4);
        bus_stop;
        model[1] = 8'h3E;
        chk(a2 && a3 && a4, "R9 restarted transfer acknowledged", {a2, a3, a4}, 3'b111);
        chk_regs("R9 registers after mid-byte restart");

        chk(oe_viol == 0, "R10 SDA drive changes with SCL high", oe_viol, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule